// File: doc/BRIEF.md
# Tagged Cache Request Tracker

This block sits between an accelerator's memory-operation stream and a pipelined first-level data cache port. Each load or store from the accelerator is given a free tag and sent to the cache on a valid/ready request channel. Store data follows one cycle after the request handshake. Two cycles after the handshake the cache may reject the request. The block keeps every outstanding request in a tag-indexed table, so it can send a rejected request again. Replays always go out ahead of new work from the accelerator.

The cache answers loads on a valid-only response channel, in any order, carrying the request's tag. The tracker uses the tag to find the load's slot in a reorder buffer, which is indexed by issue sequence. It hands load data back to the accelerator on a valid/ready output strictly in the order the loads were accepted. A busy output tells the host whether any memory traffic is still in flight.

Top module: `memreq_tracker`

## Requirements
- R1: After reset, busy, creq_valid and ld_valid are low, and op_ready is high while creq_ready is high.
- R2: Every request presents a tag below NTAGS, zero-extended into the 6-bit tag field. No tag is presented for a new request while it is still outstanding.
- R3: For a store, cwdata carries the store's write data in the cycle after its request handshake, including on a replay.
- R4: creq_kill is never asserted; the block never cancels an accepted request.
- R5: When cnack is high in the second cycle after a handshake, that request is sent again with the same tag, address and kind. op_ready stays low from the next cycle until all pending replays have been sent.
- R6: A store's tag is freed when it passes the reject stage without cnack. A load's tag is freed when its response arrives. While all NTAGS tags are in use, op_ready is low.
- R7: Responses are accepted in any cycle that cresp_valid is high, in any tag order. Load data appears on ld_data in the order the loads were accepted on the op channel.
- R8: While ld_valid is high and ld_ready is low, ld_valid stays high and ld_data stays unchanged.
- R9: While ROB_DEPTH loads are accepted but not yet delivered, op_ready is low for a load.
- R10: busy is high from the cycle after any request handshake until every tag has been freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accelerator memory operation present |
| op_ready | output | 1 | Operation accepted this cycle when op_valid is high |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_addr | input | AW | Operation address |
| op_wdata | input | DW | Store data |
| creq_valid | output | 1 | Cache request valid |
| creq_ready | input | 1 | Cache can take the request |
| creq_tag | output | 6 | Request tag |
| creq_store | output | 1 | Request is a store |
| creq_addr | output | AW | Request address |
| creq_kill | output | 1 | Cancel for the previous cycle's request (held low) |
| cwdata | output | DW | Store data for the request accepted in the previous cycle |
| cnack | input | 1 | Rejects the request accepted two cycles earlier |
| cresp_valid | input | 1 | Load response present |
| cresp_tag | input | 6 | Tag of the responding load |
| cresp_data | input | DW | Load response data |
| ld_valid | output | 1 | In-order load result valid |
| ld_ready | input | 1 | Accelerator takes the load result |
| ld_data | output | DW | In-order load result |
| busy | output | 1 | Any tag outstanding |

## Verification
The bench builds the tracker with NTAGS=4 and ROB_DEPTH=8. With four tags, a handful of loads held without responses is enough to use up the tag pool, so the tag stall of R6 can be reached. With eight reorder slots and ld_ready held low, responses can fill the reorder buffer while tags keep recycling, which brings the load stall of R9 and the hold rule of R8 within reach. A random cache stub rejects and reorders requests, so the replay path and out-of-order completion are exercised on every pass.

// File: rtl/memreq_pkg.sv
package memreq_pkg;
    localparam int TAG_W    = 6;
    localparam int MAX_TAGS = 1 << TAG_W;

    function automatic int wrap_inc(input int p, input int depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/memreq_tag_pool.sv
module memreq_tag_pool #(
    parameter int NTAGS = 16,
    localparam int IW = $clog2(NTAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [IW-1:0] free_tag,
    output logic          has_free,
    input  logic          rel_a_en,
    input  logic [IW-1:0] rel_a_tag,
    input  logic          rel_b_en,
    input  logic [IW-1:0] rel_b_tag,
    output logic          any_used
);
    typedef struct packed {
        logic [NTAGS-1:0] used;
    } pool_t;

    pool_t st_d, st_q;

    always_comb begin
        has_free = 1'b0;
        free_tag = '0;
        // lowest free index wins
        for (int i = NTAGS - 1; i >= 0; i--) begin
            if (!st_q.used[i]) begin
                has_free = 1'b1;
                free_tag = IW'(i);
            end
        end
        any_used = |st_q.used;

        st_d = st_q;
        if (rel_a_en) st_d.used[rel_a_tag] = 1'b0;
        if (rel_b_en) st_d.used[rel_b_tag] = 1'b0;
        if (alloc_en && has_free) st_d.used[free_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/memreq_replay_fifo.sv
module memreq_replay_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_pop;

    always_comb begin
        nonempty = (st_q.cnt != '0);
        head     = st_q.slot[st_q.rd];
        do_pop   = pop && nonempty;

        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wr] = push_data;
            st_d.wr = PW'(memreq_pkg::wrap_inc(int'(st_q.wr), DEPTH));
        end
        if (do_pop) st_d.rd = PW'(memreq_pkg::wrap_inc(int'(st_q.rd), DEPTH));
        st_d.cnt = st_q.cnt + CW'(push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/memreq_load_rob.sv
module memreq_load_rob #(
    parameter int DEPTH = 8,
    parameter int DW    = 64,
    localparam int RIW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_en,
    output logic [RIW-1:0] alloc_idx,
    output logic           has_space,
    input  logic           wr_en,
    input  logic [RIW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    input  logic           out_pop
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0]         done;
        logic [RIW-1:0]           head;
        logic [RIW-1:0]           tail;
        logic [CW-1:0]            cnt;
    } rob_t;

    rob_t st_d, st_q;
    logic do_alloc, do_pop;

    always_comb begin
        has_space = (st_q.cnt != CW'(DEPTH));
        alloc_idx = st_q.tail;
        out_valid = (st_q.cnt != '0) && st_q.done[st_q.head];
        out_data  = st_q.data[st_q.head];
        do_alloc  = alloc_en && has_space;
        do_pop    = out_pop && out_valid;

        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_idx] = wr_data;
            st_d.done[wr_idx] = 1'b1;
        end
        if (do_pop) begin
            st_d.done[st_q.head] = 1'b0;
            st_d.head = RIW'(memreq_pkg::wrap_inc(int'(st_q.head), DEPTH));
        end
        if (do_alloc) st_d.tail = RIW'(memreq_pkg::wrap_inc(int'(st_q.tail), DEPTH));
        st_d.cnt = st_q.cnt + CW'(do_alloc) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/memreq_tracker.sv
module memreq_tracker #(
    parameter int NTAGS     = 16,
    parameter int ROB_DEPTH = 8,
    parameter int AW        = 32,
    parameter int DW        = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         op_valid,
    output logic                         op_ready,
    input  logic                         op_is_store,
    input  logic [AW-1:0]                op_addr,
    input  logic [DW-1:0]                op_wdata,
    output logic                         creq_valid,
    input  logic                         creq_ready,
    output logic [memreq_pkg::TAG_W-1:0] creq_tag,
    output logic                         creq_store,
    output logic [AW-1:0]                creq_addr,
    output logic                         creq_kill,
    output logic [DW-1:0]                cwdata,
    input  logic                         cnack,
    input  logic                         cresp_valid,
    input  logic [memreq_pkg::TAG_W-1:0] cresp_tag,
    input  logic [DW-1:0]                cresp_data,
    output logic                         ld_valid,
    input  logic                         ld_ready,
    output logic [DW-1:0]                ld_data,
    output logic                         busy
);
    import memreq_pkg::*;

    localparam int IW  = $clog2(NTAGS);
    localparam int RIW = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1;

    generate
        if (NTAGS < 2 || NTAGS > MAX_TAGS) begin : g_bad_ntags
            $error("NTAGS must lie in 2..64");
        end
    endgenerate

    typedef struct packed {
        logic           is_st;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [RIW-1:0] rob;
    } entry_t;

    typedef struct packed {
        logic                   s1_vld;
        logic [IW-1:0]          s1_tag;
        logic                   s2_vld;
        logic [IW-1:0]          s2_tag;
        entry_t [NTAGS-1:0]     tbl;
    } trk_t;

    trk_t st_d, st_q;

    // sub-block wiring
    logic [IW-1:0]  pool_tag;
    logic           pool_free, pool_alloc, pool_used;
    logic           rel_a, rel_b;
    logic [IW-1:0]  rel_a_tag, rel_b_tag;
    logic [IW-1:0]  rp_head, rp_push_tag;
    logic           rp_has, rp_push, rp_pop;
    logic [RIW-1:0] rob_idx, rob_wr_idx;
    logic           rob_space, rob_alloc, rob_wr;
    logic [IW-1:0]  cand_tag;
    logic           new_ok, hs, take_new, s2_nack;

    always_comb begin
        st_d = st_q;

        // request selection: replays first
        new_ok     = op_valid && pool_free && (op_is_store || rob_space);
        cand_tag   = rp_has ? rp_head : pool_tag;
        creq_valid = rp_has || new_ok;
        if (rp_has) begin
            creq_store = st_q.tbl[rp_head].is_st;
            creq_addr  = st_q.tbl[rp_head].addr;
        end else begin
            creq_store = op_is_store;
            creq_addr  = op_addr;
        end
        creq_tag  = TAG_W'(cand_tag);
        creq_kill = 1'b0;
        op_ready  = !rp_has && pool_free && (op_is_store || rob_space) && creq_ready;

        hs         = creq_valid && creq_ready;
        take_new   = hs && !rp_has;
        rp_pop     = hs && rp_has;
        pool_alloc = take_new;
        rob_alloc  = take_new && !op_is_store;

        if (take_new) begin
            st_d.tbl[pool_tag].is_st = op_is_store;
            st_d.tbl[pool_tag].addr  = op_addr;
            st_d.tbl[pool_tag].wdata = op_wdata;
            st_d.tbl[pool_tag].rob   = rob_idx;
        end

        // stage tracking
        st_d.s1_vld = hs;
        st_d.s1_tag = cand_tag;
        st_d.s2_vld = st_q.s1_vld;
        st_d.s2_tag = st_q.s1_tag;
        cwdata      = st_q.tbl[st_q.s1_tag].wdata;

        // reject stage
        s2_nack     = st_q.s2_vld && cnack;
        rp_push     = s2_nack;
        rp_push_tag = st_q.s2_tag;
        rel_a       = st_q.s2_vld && !cnack && st_q.tbl[st_q.s2_tag].is_st;
        rel_a_tag   = st_q.s2_tag;

        // responses
        rel_b      = cresp_valid;
        rel_b_tag  = cresp_tag[IW-1:0];
        rob_wr     = cresp_valid;
        rob_wr_idx = st_q.tbl[rel_b_tag].rob;

        busy = pool_used;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    memreq_tag_pool #(.NTAGS(NTAGS)) pool_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(pool_alloc), .free_tag(pool_tag), .has_free(pool_free),
        .rel_a_en(rel_a), .rel_a_tag(rel_a_tag),
        .rel_b_en(rel_b), .rel_b_tag(rel_b_tag),
        .any_used(pool_used)
    );

    memreq_replay_fifo #(.DEPTH(NTAGS), .W(IW)) replay_i (
        .clk(clk), .rst_n(rst_n),
        .push(rp_push), .push_data(rp_push_tag),
        .pop(rp_pop), .head(rp_head), .nonempty(rp_has)
    );

    memreq_load_rob #(.DEPTH(ROB_DEPTH), .DW(DW)) rob_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(rob_alloc), .alloc_idx(rob_idx), .has_space(rob_space),
        .wr_en(rob_wr), .wr_idx(rob_wr_idx), .wr_data(cresp_data),
        .out_valid(ld_valid), .out_data(ld_data), .out_pop(ld_ready)
    );
endmodule

// File: rtl/memreq_tracker_chk.sv
module memreq_tracker_chk #(
    parameter int NTAGS = 16,
    parameter int DW    = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_ready,
    input logic          creq_valid,
    input logic          creq_ready,
    input logic [5:0]    creq_tag,
    input logic          creq_kill,
    input logic          s2_nack,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic [DW-1:0] ld_data,
    input logic          busy
);
    // R2
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        creq_valid |-> (int'(creq_tag) < NTAGS));

    // R4
    no_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !creq_kill);

    // R5
    replay_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_nack |=> !op_ready);

    // R8
    ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data)));

    // R10
    busy_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (creq_valid && creq_ready) |=> busy);
endmodule

bind memreq_tracker memreq_tracker_chk #(.NTAGS(NTAGS), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_ready(op_ready),
    .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_tag(creq_tag),
    .creq_kill(creq_kill), .s2_nack(s2_nack),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .busy(busy)
);

// File: tb/memreq_tracker_tb_top.sv
module memreq_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int RD = 8;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic rst_n = 1'b0;
    logic op_valid = 1'b0, op_ready, op_is_store = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_wdata = '0;
    logic creq_valid, creq_ready = 1'b1, creq_store, creq_kill;
    logic [5:0] creq_tag;
    logic [AW-1:0] creq_addr;
    logic [DW-1:0] cwdata;
    logic cnack = 1'b0, cresp_valid = 1'b0;
    logic [5:0] cresp_tag = '0;
    logic [DW-1:0] cresp_data = '0;
    logic ld_valid, ld_ready = 1'b0, busy;
    logic [DW-1:0] ld_data;

    memreq_tracker #(.NTAGS(NT), .ROB_DEPTH(RD), .AW(AW), .DW(DW)) dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    bit rdy_rand = 0, nack_en = 0, resp_en = 0, ldr_en = 0;

    logic [DW-1:0] refmem [256];
    logic [DW-1:0] cmem [256];
    logic [DW-1:0] exp_q [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // cache stub
    bit outst [NT];
    bit nacked [NT];
    logic [AW-1:0] nk_addr [NT];
    bit nk_st [NT];
    int pq_tag [$];
    logic [AW-1:0] pq_addr [$];
    bit b1_v, b2_v, b1_st, b2_st;
    int b1_tag, b2_tag;
    logic [AW-1:0] b1_addr, b2_addr;
    logic [DW-1:0] b1_data, b2_data;

    initial begin
        bit nk_prev;
        nk_prev = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                creq_ready = 1'b1; cnack = 1'b0; cresp_valid = 1'b0;
                b1_v = 0; b2_v = 0; nk_prev = 0;
                continue;
            end
            creq_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
            if (b2_v) begin
                bit nk;
                nk = nack_en && ($urandom % 4 == 0);
                cnack = nk;
                if (nk) begin
                    nacked[b2_tag] = 1; nk_addr[b2_tag] = b2_addr; nk_st[b2_tag] = b2_st;
                    outst[b2_tag] = 0;
                end else if (b2_st) begin
                    check(b2_data == refmem[b2_addr], "R3 store data on cwdata", b2_data, refmem[b2_addr]);
                    cmem[b2_addr] = b2_data;
                    outst[b2_tag] = 0;
                end else begin
                    pq_tag.push_back(b2_tag);
                    pq_addr.push_back(b2_addr);
                end
            end else cnack = 1'b0;
            if (resp_en && pq_tag.size() > 0 && ($urandom % 2 == 0)) begin
                int idx;
                idx = int'($urandom % pq_tag.size());
                cresp_valid = 1'b1;
                cresp_tag   = 6'(pq_tag[idx]);
                cresp_data  = cmem[pq_addr[idx]];
                outst[pq_tag[idx]] = 0;
                pq_tag.delete(idx);
                pq_addr.delete(idx);
            end else cresp_valid = 1'b0;
            #1;
            if (nk_prev)
                check(!op_ready, "R5 op_ready low after reject", op_ready, 0);
            nk_prev = b2_v && cnack;
            if (b1_v) b1_data = cwdata;
            b2_v = b1_v; b2_tag = b1_tag; b2_st = b1_st; b2_addr = b1_addr; b2_data = b1_data;
            b1_v = creq_valid && creq_ready;
            if (b1_v) begin
                b1_tag = int'(creq_tag); b1_st = creq_store; b1_addr = creq_addr;
                check(b1_tag < NT, "R2 tag range", creq_tag, NT - 1);
                check(!creq_kill, "R4 kill low", creq_kill, 0);
                if (b1_tag < NT) begin
                    if (nacked[b1_tag]) begin
                        check(creq_addr == nk_addr[b1_tag] && creq_store == nk_st[b1_tag],
                              "R5 replay same op", creq_addr, nk_addr[b1_tag]);
                        nacked[b1_tag] = 0;
                    end else begin
                        check(!outst[b1_tag], "R2 tag unique", outst[b1_tag], 0);
                    end
                    outst[b1_tag] = 1;
                end
            end
        end
    end

    // monitor: in-order load results
    initial begin
        forever begin
            @(negedge clk);
            ld_ready = ldr_en ? ($urandom % 3 != 0) : 1'b0;
            #3;
            if (rst_n && ld_valid && ld_ready) begin
                if (exp_q.size() == 0) check(0, "R7 unexpected load", ld_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(ld_data == e, "R7 load order/data", ld_data, e);
                end
            end
        end
    end

    // driver
    task automatic issue(input bit st, input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        op_valid = 1'b1; op_is_store = st; op_addr = AW'(addr); op_wdata = data;
        forever begin
            #2;
            if (op_ready) begin
                if (st) refmem[addr] = data;
                else exp_q.push_back(refmem[addr]);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy && exp_q.size() == 0) break;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin refmem[i] = '0; cmem[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        check(!busy, "R1 busy after reset", busy, 0);
        check(!creq_valid, "R1 creq_valid after reset", creq_valid, 0);
        check(!ld_valid, "R1 ld_valid after reset", ld_valid, 0);
        check(op_ready, "R1 op_ready after reset", op_ready, 1);

        // stores under random rejects and backpressure
        rdy_rand = 1; nack_en = 1; resp_en = 1; ldr_en = 1;
        issue(1, 0, 32'hA5A5_0000);
        #1 check(busy, "R10 busy while store in flight", busy, 1);
        for (int i = 1; i < 20; i++) issue(1, i, $urandom);
        wait_idle();
        check(!busy, "R10 busy low after drain", busy, 1);

        // loads, random reject / response order / ld_ready
        for (int i = 0; i < 20; i++) issue(0, (i * 7) % 20, '0);
        wait_idle();
        check(exp_q.size() == 0, "R7 all loads delivered", exp_q.size(), 0);

        // tag exhaustion
        rdy_rand = 0; nack_en = 0; resp_en = 0;
        for (int i = 0; i < NT; i++) issue(0, i, '0);
        @(negedge clk);
        op_valid = 1'b1; op_is_store = 1'b0; op_addr = 8'd4;
        for (int k = 0; k < 4; k++) begin
            #2 check(!op_ready, "R6 stall with all tags used", op_ready, 0);
            @(negedge clk);
        end
        check(busy, "R10 busy with tags held", busy, 1);
        op_valid = 1'b0;
        resp_en = 1;
        issue(0, 4, '0);
        wait_idle();

        // reorder buffer full
        ldr_en = 0;
        for (int i = 0; i < RD; i++) issue(0, 10 + i, '0);
        repeat (40) @(negedge clk);
        op_valid = 1'b1; op_is_store = 1'b0; op_addr = 8'd2;
        #2 check(!op_ready, "R9 load stall with buffer full", op_ready, 0);
        check(ld_valid, "R8 ld_valid held", ld_valid, 1);
        begin
            logic [DW-1:0] held;
            held = ld_data;
            check(held == exp_q[0], "R7 head load data", held, exp_q[0]);
            repeat (3) @(negedge clk);
            #2 check(ld_valid && ld_data == held, "R8 ld_data stable", ld_data, held);
            check(!op_ready, "R9 load stall persists", op_ready, 0);
        end
        op_valid = 1'b0;
        issue(1, 30, 32'h1234_5678);
        ldr_en = 1;
        issue(0, 2, '0);
        issue(0, 30, '0);
        wait_idle();
        check(!busy && exp_q.size() == 0, "R10 idle at end", busy, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule